// File: doc/BRIEF.md
# Complementary Pair Dead-Time Inserter

This block drives one pair of output pins, an even pin and an odd pin, from two PWM source waveforms. In independent mode each pin is a registered copy of its own source. In paired mode the odd source is ignored. The even pin follows the even source and the odd pin follows the inverse of the even source, so the period and duty of both pins come from the even source alone. In this mode a programmable dead time is inserted before each rising pin edge, so the two pins are never high together.

Each pin has its own edge-delay state machine with three states.

- `DT_LOW`: the pin is low.
- `DT_HOLD`: the source is high and the dead time is still being counted.
- `DT_HIGH`: the pin is high.

The transitions between the states are named as follows.

- *arm* goes from `DT_LOW` to `DT_HOLD` when the source is high and the dead time is not zero.
- *fire* goes to `DT_HIGH`. From `DT_LOW` it is taken when the source is high and the dead time is zero. From `DT_HOLD` it is taken when the counted cycles reach the dead time.
- *abort* goes from `DT_HOLD` to `DT_LOW` when the source drops before the count completes.
- *release* goes from `DT_HIGH` to `DT_LOW` when the source drops.

A routing stage chooses what each state machine sees: its request, and the effective dead time, which is zero in independent mode. The count is measured in clock cycles of the block clock.

Top module: `dtgen_pair`

## Requirements
- R1: While `rst` is sampled high, both pins are low after that clock edge.
- R2: With `pair_en` low, each pin equals its own source as sampled at the previous rising clock edge, whatever `dead_cnt` holds.
- R3: With `pair_en` high, the even pin is derived from `pwm_even`, the odd pin is derived from the inverse of `pwm_even`, and `pwm_odd` has no effect on either pin.
- R4: In paired mode, when a request (`pwm_even` for the even pin, `!pwm_even` for the odd pin) is first sampled high at edge k and stays high, the pin goes high after edge k+`dead_cnt`.
- R5: A request sampled low at any edge drives its pin low after that same edge, with no dead time.
- R6: With `dead_cnt` equal to 0 in paired mode, the odd pin is the exact complement of the even pin, with no gap.
- R7: A request that is high for L consecutive edges yields L-`dead_cnt` high cycles on its pin when L > `dead_cnt`, and no high cycle at all when L ≤ `dead_cnt`.
- R8: After any edge at which `pair_en` is sampled high, the even pin and the odd pin are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the dead-time tick |
| rst | input | 1 | Synchronous reset, active high |
| pair_en | input | 1 | 1 = complementary pair mode, 0 = independent mode |
| dead_cnt | input | 8 | Dead time in clock cycles (paired mode only) |
| pwm_even | input | 1 | Even-channel PWM source |
| pwm_odd | input | 1 | Odd-channel PWM source (ignored when paired) |
| pin_even | output | 1 | Even output pin |
| pin_odd | output | 1 | Odd output pin |

## Verification
Every pin is a registered state output. A source change sampled at one rising edge therefore appears on the pin one cycle later. The exceptions are a rising request in paired mode, which appears `dead_cnt` edges later, and a request that drops before that, which never appears. The bench drives inputs at the falling edge. At each following falling edge it compares both pins with a reference model that is updated with the inputs the next rising edge will sample. The model keeps the run length of each request, so a check lands on exactly the cycle the pin is due to change. This also holds when `dead_cnt` or `pair_en` changes during a run.

// File: rtl/dtgen_pkg.sv
package dtgen_pkg;

    typedef enum logic [1:0] {
        DT_LOW  = 2'd0,
        DT_HOLD = 2'd1,
        DT_HIGH = 2'd2
    } dt_state_e;

endpackage

// File: rtl/dtgen_route.sv
module dtgen_route #(
    parameter int DT_W = 8
) (
    input  logic            pair_en,
    input  logic [DT_W-1:0] dead_cnt,
    input  logic            pwm_even,
    input  logic            pwm_odd,
    output logic            req_even,
    output logic            req_odd,
    output logic [DT_W-1:0] dly_even,
    output logic [DT_W-1:0] dly_odd
);

    // Paired mode: both requests come from the even source and both
    // pins get the programmed dead time. Independent mode: each pin
    // follows its own source with no delay.
    always_comb begin
        req_even = pwm_even;
        if (pair_en) begin
            req_odd  = ~pwm_even;
            dly_even = dead_cnt;
            dly_odd  = dead_cnt;
        end else begin
            req_odd  = pwm_odd;
            dly_even = '0;
            dly_odd  = '0;
        end
    end

endmodule

// File: rtl/dtgen_edge_delay.sv
module dtgen_edge_delay
    import dtgen_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [DT_W-1:0] dly,
    output logic            pin
);

    dt_state_e       state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: arm, fire, abort, release
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DT_LOW: begin
                cnt_d = '0;
                if (req) begin
                    if (dly == '0) begin
                        state_d = DT_HIGH;            // fire
                    end else begin
                        state_d = DT_HOLD;            // arm
                        cnt_d   = DT_W'(1);
                    end
                end
            end
            DT_HOLD: begin
                if (!req) begin
                    state_d = DT_LOW;                 // abort
                    cnt_d   = '0;
                end else if (cnt_q >= dly) begin
                    state_d = DT_HIGH;                // fire
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + DT_W'(1);
                end
            end
            DT_HIGH: begin
                cnt_d = '0;
                if (!req) state_d = DT_LOW;           // release
            end
            default: begin
                state_d = DT_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    // output decode
    always_comb begin
        pin = (state_q == DT_HIGH);
    end

    // R5: a low request drops the pin at the very next edge
    a_r5_fall_now: assert property (@(posedge clk) disable iff (rst)
        !req |=> !pin);

    // R4: arming with a nonzero dead time keeps the pin low one more cycle
    a_r4_rise_held: assert property (@(posedge clk) disable iff (rst)
        (!pin && req && dly != '0 && state_q == DT_LOW) |=> !pin);

    // R7: the pin is never high unless the request was high at the edge before
    a_r7_no_phantom: assert property (@(posedge clk) disable iff (rst)
        $rose(pin) |-> $past(req));

endmodule

// File: rtl/dtgen_pair.sv
module dtgen_pair #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pair_en,
    input  logic [DT_W-1:0] dead_cnt,
    input  logic            pwm_even,
    input  logic            pwm_odd,
    output logic            pin_even,
    output logic            pin_odd
);

    localparam int NCH = 2;

    logic [NCH-1:0]  req;
    logic [DT_W-1:0] dly [NCH];
    logic [NCH-1:0]  pin;

    dtgen_route #(.DT_W(DT_W)) u_route (
        .pair_en  (pair_en),
        .dead_cnt (dead_cnt),
        .pwm_even (pwm_even),
        .pwm_odd  (pwm_odd),
        .req_even (req[0]),
        .req_odd  (req[1]),
        .dly_even (dly[0]),
        .dly_odd  (dly[1])
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dtgen_edge_delay #(.DT_W(DT_W)) u_dly (
            .clk (clk),
            .rst (rst),
            .req (req[g]),
            .dly (dly[g]),
            .pin (pin[g])
        );
    end

    assign pin_even = pin[0];
    assign pin_odd  = pin[1];

    // R1: reset clears both pins
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!pin_even && !pin_odd));

    // R8: paired pins never overlap
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        pair_en |=> !(pin_even && pin_odd));

    // R2: independent mode is a one-cycle copy of each source
    a_r2_indep_copy: assert property (@(posedge clk) disable iff (rst)
        !pair_en |=> (pin_even == $past(pwm_even) && pin_odd == $past(pwm_odd)));

    // R3: when paired, the odd pin never rises while the even source was high
    a_r3_odd_from_even: assert property (@(posedge clk) disable iff (rst)
        (pair_en && pwm_even) |=> !pin_odd);

endmodule

// File: tb/dtgen_pair_tb.sv
module dtgen_pair_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       pair_en;
    logic [7:0] dead_cnt;
    logic       pwm_even;
    logic       pwm_odd;
    logic       pin_even;
    logic       pin_odd;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int   run_e = 0, run_o = 0;
    logic exp_e = 1'b0, exp_o = 1'b0;
    logic exp_pair = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dtgen_pair u_dut (
        .clk      (clk),
        .rst      (rst),
        .pair_en  (pair_en),
        .dead_cnt (dead_cnt),
        .pwm_even (pwm_even),
        .pwm_odd  (pwm_odd),
        .pin_even (pin_even),
        .pin_odd  (pin_odd)
    );

    function automatic logic next_pin(input logic req, input logic cur, input int run, input int d);
        // run counts consecutive high edges including this one
        if (!req) return 1'b0;
        return cur || ((run - 1) >= d);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare current pins with the model, then apply new inputs and advance the model
    task automatic step(input logic pe, input logic [7:0] dc, input logic se, input logic so, input string tag);
        logic re, ro;
        int   d;
        check({tag, " even"}, pin_even, exp_e);
        check({tag, " odd"},  pin_odd,  exp_o);
        if (exp_pair) check("R8 overlap", pin_even & pin_odd, 1'b0);
        pair_en = pe; dead_cnt = dc; pwm_even = se; pwm_odd = so;
        re = se;
        ro = pe ? ~se : so;
        d  = pe ? int'(dc) : 0;
        run_e = re ? run_e + 1 : 0;
        run_o = ro ? run_o + 1 : 0;
        exp_e = next_pin(re, exp_e, run_e, d);
        exp_o = next_pin(ro, exp_o, run_o, d);
        exp_pair = pe;
        @(negedge clk);
    endtask

    task automatic hold(input int n, input logic pe, input logic [7:0] dc, input logic se, input logic so, input string tag);
        for (int i = 0; i < n; i++) step(pe, dc, se, so, tag);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        rst = 1'b1; pair_en = 1'b1; dead_cnt = 8'd3; pwm_even = 1'b1; pwm_odd = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 reset even", pin_even, 1'b0);
        check("R1 reset odd",  pin_odd,  1'b0);
        rst = 1'b0;
        pwm_even = 1'b0; pwm_odd = 1'b0;
        run_e = 0; run_o = 0; exp_e = 0; exp_o = 0; exp_pair = 1'b1;
        @(negedge clk);
        // model saw inputs sampled at the edge just passed; resync
        exp_e = 1'b0; exp_o = 1'b0; run_e = 0; run_o = 0; exp_pair = 1'b0;
        pair_en = 1'b0;
        @(negedge clk);

        // R2 / R9: independent mode ignores dead_cnt
        hold(3, 1'b0, 8'd50, 1'b1, 1'b1, "R2 both high");
        hold(2, 1'b0, 8'd50, 1'b0, 1'b1, "R2 odd only");
        hold(2, 1'b0, 8'd50, 1'b1, 1'b0, "R2 even only");
        hold(2, 1'b0, 8'd50, 1'b0, 1'b0, "R2 low");

        // R6: zero dead time gives exact complements
        hold(4, 1'b1, 8'd0, 1'b1, 1'b0, "R6 dt0 high");
        check("R6 complement", pin_odd, ~pin_even);
        hold(3, 1'b1, 8'd0, 1'b0, 1'b1, "R6 dt0 low");
        check("R6 complement", pin_odd, ~pin_even);

        // R3: odd source toggles with no effect when paired
        hold(3, 1'b1, 8'd0, 1'b1, 1'b1, "R3 odd ignored");
        hold(3, 1'b1, 8'd0, 1'b1, 1'b0, "R3 odd ignored");

        // R4 / R5: dead time 3 on both edges
        hold(8, 1'b1, 8'd3, 1'b0, 1'b0, "R4 odd rise");
        hold(8, 1'b1, 8'd3, 1'b1, 1'b0, "R4 even rise R5");

        // R7: short pulses swallowed, longer pulse trimmed
        hold(6, 1'b1, 8'd4, 1'b0, 1'b0, "R7 settle");
        hold(4, 1'b1, 8'd4, 1'b1, 1'b0, "R7 short even");
        hold(3, 1'b1, 8'd4, 1'b0, 1'b0, "R7 short odd");
        hold(6, 1'b1, 8'd4, 1'b1, 1'b0, "R7 long even");
        hold(6, 1'b1, 8'd4, 1'b0, 1'b0, "R7 long odd");

        // maximum dead time
        hold(260, 1'b1, 8'd255, 1'b1, 1'b0, "R4 max dt");
        hold(4, 1'b1, 8'd255, 1'b0, 1'b0, "R5 max dt fall");

        // constrained random
        seed = 12345;
        void'($urandom(seed));
        for (int seg = 0; seg < 400; seg++) begin
            logic       pe;
            logic [7:0] dc;
            int         len;
            pe  = ($urandom % 4) != 0;
            dc  = ($urandom % 16 == 0) ? 8'($urandom % 256) : 8'($urandom % 10);
            len = 1 + ($urandom % 14);
            for (int i = 0; i < len; i++)
                step(pe, dc, 1'($urandom), 1'($urandom % 3 == 0 ? 1 : 0), "R4 R5 R7 random");
            for (int i = 0; i < int'(dc) % 20 + 2; i++)
                step(pe, dc, (i < 2) ? 1'b1 : 1'b0, 1'($urandom), "R7 random run");
        end
        step(1'b1, 8'd0, 1'b0, 1'b0, "final");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule